// File: doc/BRIEF.md
# Dual-Channel Serial ADC Sequencer

This block drives a two-channel, 10-bit serial analog-to-digital converter over a four-wire SPI link. A single-clock pulse on the start input begins a run. The run is two framed transfers: channel 0 first, then channel 1. Each frame holds the select line low and sends a four-bit command on MOSI. One unused clock follows the command, and then ten result bits are read from MISO, most significant bit first.

The result of the first frame is held in a staging register until the second frame ends. Both words are then written to the outputs on the same clock edge, and a one-cycle valid strobe marks them. A busy flag covers the whole run. A start pulse that arrives during a run is dropped. The serial clock is derived from the system clock, with a half-period set by a parameter. Between the two frames the select line stays high for a fixed gap of system clocks.

Top module: `adc2ch_spi_seq`

## Requirements
- R1: Reset is synchronous and active low. While it is low: cs_n=1, sclk=0, mosi=0, busy=0, words_valid=0, and both words are cleared to 0. A reset during a run abandons the run.
- R2: While busy is low, an en_pulse sampled high at a clock edge starts a run. busy goes to 1 and cs_n goes to 0 at that same edge.
- R3: Each frame holds cs_n low for exactly 31*HALF_DIV clocks and contains exactly 15 SCLK rising edges. Each SCLK level lasts HALF_DIV clocks. sclk is 0 whenever cs_n is 1.
- R4: On the first four SCLK rising edges of a frame, MOSI carries, in order: 1 (start), 1 (single-ended), the channel number (0 in the first frame, 1 in the second), and 1. Read as a 4-bit value this is 13 for channel 0 and 15 for channel 1. MOSI only changes while sclk is 0, and it is 0 after the command.
- R5: MISO is sampled on SCLK rising edges 6 to 15 of a frame and assembled MSB first (edge 6 gives bit 9). The value of MISO on edge 5, the null bit, is not used.
- R6: The first frame's word appears on ch0_word and the second frame's word on ch1_word.
- R7: words_valid is high for exactly one clock. It rises at the same edge at which both words take their new values. That edge comes 62*HALF_DIV+GAP_CYC clocks after the edge that sampled en_pulse.
- R8: busy stays high from the start edge until the edge at which words_valid rises, and falls at that edge.
- R9: Between the two frames of a run, cs_n stays high for exactly GAP_CYC clocks.
- R10: An en_pulse sampled while busy is high has no effect. The run produces exactly two frames, and no further frame follows.
- R11: ch0_word and ch1_word hold their values in every cycle in which words_valid is low (reset aside).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_pulse | input | 1 | One-clock start request |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select, one low period per frame |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial command to the converter |
| ch0_word | output | DATA_W | Latest channel 0 result |
| ch1_word | output | DATA_W | Latest channel 1 result |
| words_valid | output | 1 | One-cycle strobe when both words are refreshed |
| busy | output | 1 | High while a run is in progress |

## Verification
With HALF_DIV=4 and GAP_CYC=6, a run takes 254 clocks. busy and cs_n respond at the edge that samples the start pulse, and the bench checks them at the next falling clock edge. The bench then counts falling clock edges until words_valid appears and expects exactly 254. It checks the strobe is gone one cycle later.

A converter model drives MISO just after each SCLK fall that it observes. It also records, on each SCLK rise, the command bit, along with the frame length and gap length in clocks. Every comparison is made at a falling clock edge, half a period after the register updates that cause it.

// File: rtl/adc2ch_pkg.sv
// Shared definitions for the dual-channel serial ADC sequencer.
// Assumes the converter takes a fixed four-bit command followed by one null clock.
package adc2ch_pkg;

    localparam int CMD_BITS  = 4;
    localparam int NULL_BITS = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_XFER0 = 2'd1,
        SEQ_GAP   = 2'd2,
        SEQ_XFER1 = 2'd3
    } seq_state_t;

    // Command word sent MSB first: start, single-ended, channel, MSB-first format.
    function automatic logic [CMD_BITS-1:0] make_cmd(input logic chan);
        return {1'b1, 1'b1, chan, 1'b1};
    endfunction

endpackage

// File: rtl/adc2ch_tick.sv
// Divider that emits a one-clock tick every HALF_DIV clocks while run is high.
// Assumes HALF_DIV >= 2; the count restarts from zero whenever run is low.
module adc2ch_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == TOP);

    // Count system clocks within one SCLK half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == TOP) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc2ch_capture.sv
// MSB-first serial-in shift register for one conversion result.
// Assumes clr and shift_en are never high together.
module adc2ch_capture #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    // Shift the sampled bit in at the low end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[W-2:0], din};
        end
    end
endmodule

// File: rtl/adc2ch_xfer.sv
// One chip-select frame: command bits, a null clock, then DATA_W result bits.
// SCLK idles low. MOSI is updated on falling phases and MISO is sampled on rising phases.
// Assumes start is only raised while no frame is active; done is a one-clock pulse.
module adc2ch_xfer
    import adc2ch_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chan,
    input  logic              miso,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int FRAME     = CMD_BITS + NULL_BITS + DATA_W;
    localparam int LAST_HALF = 2 * FRAME;
    localparam int HW        = $clog2(LAST_HALF + 1);
    localparam int BW        = $clog2(FRAME + 1);
    localparam logic [HW-1:0] LAST_H = HW'(LAST_HALF);
    localparam logic [BW-1:0] SKIP_B = BW'(CMD_BITS + NULL_BITS);

    logic                active_q;
    logic [HW-1:0]       half_q;
    logic [BW-1:0]       bit_q;
    logic [CMD_BITS-1:0] cmd_q;
    logic                cs_n_q;
    logic                sclk_q;
    logic                mosi_q;
    logic                tick;
    logic                is_last;
    logic                rise_now;
    logic                fall_now;
    logic                sample_en;
    logic                begin_now;
    logic [CMD_BITS-1:0] cmd_w;

    adc2ch_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (active_q),
        .tick (tick)
    );

    assign cmd_w     = make_cmd(chan);
    assign begin_now = start && !active_q;
    assign is_last   = active_q && tick && (half_q == LAST_H);
    assign rise_now  = active_q && tick && !is_last && !half_q[0];
    assign fall_now  = active_q && tick && half_q[0];
    assign sample_en = rise_now && (bit_q >= SKIP_B);

    adc2ch_capture #(.W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (begin_now),
        .shift_en(sample_en),
        .din     (miso),
        .word    (rx_word)
    );

    // Frame sequencing: select, clock phases, command shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            half_q   <= '0;
            bit_q    <= '0;
            cmd_q    <= '0;
            cs_n_q   <= 1'b1;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b0;
        end else if (begin_now) begin
            active_q <= 1'b1;
            half_q   <= '0;
            bit_q    <= '0;
            cs_n_q   <= 1'b0;
            sclk_q   <= 1'b0;
            mosi_q   <= cmd_w[CMD_BITS-1];
            cmd_q    <= {cmd_w[CMD_BITS-2:0], 1'b0};
        end else if (is_last) begin
            active_q <= 1'b0;
            cs_n_q   <= 1'b1;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b0;
        end else if (rise_now) begin
            half_q <= half_q + 1'b1;
            sclk_q <= 1'b1;
        end else if (fall_now) begin
            half_q <= half_q + 1'b1;
            sclk_q <= 1'b0;
            bit_q  <= bit_q + 1'b1;
            mosi_q <= cmd_q[CMD_BITS-1];
            cmd_q  <= {cmd_q[CMD_BITS-2:0], 1'b0};
        end
    end

    assign cs_n = cs_n_q;
    assign sclk = sclk_q;
    assign mosi = mosi_q;
    assign done = is_last;
endmodule

// File: rtl/adc2ch_spi_seq.sv
// Top of the dual-channel serial ADC sequencer.
// Runs channel 0 then channel 1 per start pulse and publishes both words with one strobe.
// Assumes HALF_DIV >= 2 and GAP_CYC >= 2; start pulses during a run are dropped.
module adc2ch_spi_seq
    import adc2ch_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int HALF_DIV = 4,
    parameter int GAP_CYC  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_pulse,
    input  logic              miso,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] ch0_word,
    output logic [DATA_W-1:0] ch1_word,
    output logic              words_valid,
    output logic              busy
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_END = GW'(GAP_CYC - 1);

    seq_state_t        state_q;
    logic [GW-1:0]     gap_q;
    logic [DATA_W-1:0] stage0_q;
    logic [DATA_W-1:0] ch0_q;
    logic [DATA_W-1:0] ch1_q;
    logic              valid_q;
    logic              busy_q;
    logic              xfer_start;
    logic              xfer_chan;
    logic              xfer_done;
    logic [DATA_W-1:0] xfer_word;

    assign xfer_start = ((state_q == SEQ_IDLE) && en_pulse) ||
                        ((state_q == SEQ_GAP) && (gap_q == GAP_END));
    assign xfer_chan  = (state_q == SEQ_GAP);

    adc2ch_xfer #(
        .DATA_W  (DATA_W),
        .HALF_DIV(HALF_DIV)
    ) u_xfer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (xfer_start),
        .chan   (xfer_chan),
        .miso   (miso),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .mosi   (mosi),
        .done   (xfer_done),
        .rx_word(xfer_word)
    );

    // Run sequencing, staging of channel 0 and joint publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            gap_q    <= '0;
            stage0_q <= '0;
            ch0_q    <= '0;
            ch1_q    <= '0;
            valid_q  <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (en_pulse) begin
                        state_q <= SEQ_XFER0;
                        busy_q  <= 1'b1;
                    end
                end
                SEQ_XFER0: begin
                    if (xfer_done) begin
                        stage0_q <= xfer_word;
                        gap_q    <= '0;
                        state_q  <= SEQ_GAP;
                    end
                end
                SEQ_GAP: begin
                    gap_q <= gap_q + 1'b1;
                    if (gap_q == GAP_END) begin
                        state_q <= SEQ_XFER1;
                    end
                end
                SEQ_XFER1: begin
                    if (xfer_done) begin
                        ch0_q   <= stage0_q;
                        ch1_q   <= xfer_word;
                        valid_q <= 1'b1;
                        busy_q  <= 1'b0;
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign ch0_word    = ch0_q;
    assign ch1_word    = ch1_q;
    assign words_valid = valid_q;
    assign busy        = busy_q;
endmodule

// File: rtl/adc2ch_spi_seq_chk.sv
// Port-level property checker for adc2ch_spi_seq, attached by bind below.
// Assumes the synchronous active-low reset is applied from time zero.
module adc2ch_spi_seq_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_pulse,
    input logic              cs_n,
    input logic              sclk,
    input logic              mosi,
    input logic [DATA_W-1:0] ch0_word,
    input logic [DATA_W-1:0] ch1_word,
    input logic              words_valid,
    input logic              busy
);
    AST_START_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && en_pulse) |=> (busy && !cs_n)); // R2

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R3

    AST_MOSI_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(mosi)) |-> !sclk); // R4

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        words_valid |=> !words_valid); // R7

    AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        words_valid |-> (!busy && $past(busy))); // R8

    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n); // R8

    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !words_valid) |-> ($stable(ch0_word) && $stable(ch1_word))); // R11
endmodule

bind adc2ch_spi_seq adc2ch_spi_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_pulse   (en_pulse),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .mosi       (mosi),
    .ch0_word   (ch0_word),
    .ch1_word   (ch1_word),
    .words_valid(words_valid),
    .busy       (busy)
);

// File: tb/adc2ch_spi_seq_tb.sv
// Self-checking bench: vector table of converter results, then directed reset tests.
module adc2ch_spi_seq_tb;
    localparam int W     = 10;
    localparam int H     = 4;
    localparam int G     = 6;
    localparam int SKIP  = 5;
    localparam int FRAME = 15;
    localparam int LAT   = 62 * H + G;
    localparam int NVEC  = 6;
    // {poke enable mid-run, channel 0 word, channel 1 word}
    localparam logic [2*W:0] VECS [NVEC] = '{
        {1'b0, 10'h000, 10'h3FF},
        {1'b0, 10'h3FF, 10'h000},
        {1'b0, 10'h2AA, 10'h155},
        {1'b1, 10'h155, 10'h2AA},
        {1'b1, 10'h201, 10'h180},
        {1'b0, 10'h001, 10'h200}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_pulse = 1'b0;
    logic         miso = 1'b0;
    logic         cs_n;
    logic         sclk;
    logic         mosi;
    logic [W-1:0] ch0_word;
    logic [W-1:0] ch1_word;
    logic         words_valid;
    logic         busy;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    logic [W-1:0] cur_w [2];
    int           got_cmd [2];
    int           got_rise [2];
    int           got_low [2];
    int           got_gap;
    int           cs_falls = 0;

    always #10 clk = ~clk;

    adc2ch_spi_seq #(.DATA_W(W), .HALF_DIV(H), .GAP_CYC(G)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_pulse(en_pulse), .miso(miso),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .ch0_word(ch0_word),
        .ch1_word(ch1_word), .words_valid(words_valid), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model and link monitor, sampled at falling clock edges.
    initial begin
        logic p_cs = 1'b1, p_sclk = 1'b0, p_busy = 1'b0;
        int xf = 0, fcnt = 0, rcnt = 0, cmd = 0, low = 0, gap = 0;
        forever begin
            @(negedge clk);
            if (!p_busy && busy) xf = 0;
            if (p_cs && !cs_n) begin
                cs_falls++;
                fcnt = 0; rcnt = 0; cmd = 0; low = 0;
                if (xf == 1) got_gap = gap;
                miso = 1'b0;
            end
            if (!cs_n) low++;
            if (cs_n) gap++;
            if (!p_sclk && sclk) begin
                if (rcnt < 4) cmd = (cmd << 1) | int'(mosi);
                rcnt++;
            end
            if (p_sclk && !sclk) begin
                fcnt++;
                if (fcnt >= SKIP && fcnt < FRAME)
                    miso = cur_w[xf & 1][W-1-(fcnt-SKIP)];
                else
                    miso = 1'b0;
            end
            if (!p_cs && cs_n) begin
                if (xf < 2) begin
                    got_cmd[xf] = cmd; got_rise[xf] = rcnt; got_low[xf] = low;
                end
                xf++;
                gap = 1;
            end
            p_cs = cs_n; p_sclk = sclk; p_busy = busy;
        end
    end

    task automatic run_vec(input logic [W-1:0] w0, input logic [W-1:0] w1, input bit poke);
        int cnt = 0;
        int falls0;
        bit early_drop = 0;
        cur_w[0] = w0; cur_w[1] = w1;
        falls0 = cs_falls;
        @(negedge clk) en_pulse = 1'b1;
        @(negedge clk) en_pulse = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(cs_n == 1'b0, "R2 cs_n after start", int'(cs_n), 0);
        while (!words_valid && cnt < 2000) begin
            @(negedge clk);
            cnt++;
            if (cnt == 41) en_pulse = 1'b0;
            if (poke && cnt == 40) en_pulse = 1'b1;
            if (!words_valid && !busy) early_drop = 1;
        end
        chk(cnt == LAT, "R7 valid latency", cnt, LAT);
        chk(busy == 1'b0 && !early_drop, "R8 busy window", int'(early_drop), 0);
        chk(ch0_word == w0, "R5 R6 channel 0 word", int'(ch0_word), int'(w0));
        chk(ch1_word == w1, "R5 R6 channel 1 word", int'(ch1_word), int'(w1));
        chk(got_cmd[0] == 13, "R4 command frame 0", got_cmd[0], 13);
        chk(got_cmd[1] == 15, "R4 command frame 1", got_cmd[1], 15);
        chk(got_rise[0] == FRAME && got_rise[1] == FRAME, "R3 sclk rises",
            got_rise[0] + got_rise[1], 2 * FRAME);
        chk(got_low[0] == 31 * H && got_low[1] == 31 * H, "R3 cs low length",
            got_low[0] + got_low[1], 62 * H);
        chk(got_gap == G, "R9 gap", got_gap, G);
        @(negedge clk);
        chk(words_valid == 1'b0, "R7 strobe width", int'(words_valid), 0);
        chk(ch0_word == w0 && ch1_word == w1, "R11 words held", int'(ch0_word), int'(w0));
        if (poke) begin
            repeat (300) @(negedge clk);
            chk(cs_falls - falls0 == 2, "R10 ignored enable frames", cs_falls - falls0, 2);
            chk(busy == 1'b0, "R10 ignored enable busy", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 link idle in reset",
            int'({cs_n, sclk, mosi}), 4);
        chk(busy == 1'b0 && words_valid == 1'b0, "R1 flags in reset",
            int'({busy, words_valid}), 0);
        chk(ch0_word == '0 && ch1_word == '0, "R1 words in reset", int'(ch0_word), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i][2*W-1:W], VECS[i][W-1:0], VECS[i][2*W]);
            repeat (5) @(negedge clk);
        end
        // R1 reset in the middle of a run abandons it and clears the words
        cur_w[0] = 10'h0F0; cur_w[1] = 10'h00F;
        @(negedge clk) en_pulse = 1'b1;
        @(negedge clk) en_pulse = 1'b0;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 mid-run reset link", int'({cs_n, sclk}), 2);
        chk(busy == 1'b0 && words_valid == 1'b0, "R1 mid-run reset flags",
            int'({busy, words_valid}), 0);
        chk(ch0_word == '0 && ch1_word == '0, "R1 mid-run reset words", int'(ch0_word), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(negedge clk);
        run_vec(10'h3C3, 10'h0F0, 1'b0);
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule